// File: doc/BRIEF.md
# Debug Port Pin Release Controller

This block arbitrates five shared pads between a combined serial-wire/JTAG debug port and a general-purpose I/O controller. Software writes a 3-bit mode field over a simple peripheral register bus. The mode selects how many of the five pads stay with the debug port. The pads are the test-reset input, the data input, the mode-select/serial-data pad, the test-clock/serial-clock pad and the data output. For every pad the block drives an ownership flag, pull-up and pull-down enables, and (for the four input pads) the value that the debug core sees.

A pad never leaves the debug port in one step. On the clock edge that completes a write, every pad that the new mode releases enters a forcing cycle. In that cycle the core input is tied to a safe level, the pad is still owned by the debug side and its pulls stay on. On the following edge ownership passes to the GPIO controller. A pad that the new mode reclaims returns to debug ownership on the completing edge, with no forcing step. When the bridge's write buffer is flagged full and a write changes the set of released pads, the bus ready signal is held low for one extra cycle.

Top module: `swj_pin_release`

## Requirements
- R1: While and after synchronous reset (rst_n low), no pad is GPIO-owned: gpio_own = 00000, pu_en = 00111, pd_en = 01000, core_in follows pad_in, and pready is high.
- R2: The released-pad set is decoded from pwdata: 000 releases none; 001 releases bit 0 (test-reset); 010 releases bits 0, 1 and 4 (test-reset, data-in, data-out); 100 and every other code release all five bits. Pad bit order is 0 test-reset, 1 data-in, 2 mode-select, 3 test-clock, 4 data-out.
- R3: A newly released pad spends exactly one cycle after the completing write edge with gpio_own low and its core input forced. gpio_own rises in the cycle after that.
- R4: Whenever a pad is released or being released, its core input is forced: bits 0, 1 and 2 read 1 and bit 3 reads 0. Otherwise core_in equals pad_in.
- R5: While a pad is debug-owned (gpio_own low, forcing cycle included), pu_en is set on bits 0, 1 and 2 and pd_en on bit 3. Bit 4 has no pull. A GPIO-owned pad has both enables low.
- R6: A pad that a write reclaims shows gpio_own low and core_in equal to pad_in in the first cycle after the completing edge.
- R7: A write access whose decoded set differs from the current one while buf_full is high sees pready low for exactly one cycle. It completes in the next cycle, and forcing does not start during the stall.
- R8: A write access that leaves the released set unchanged, or that happens while buf_full is low, has pready high at once.
- R9: A bus access without pwrite, or without penable, changes no ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| pwdata | input | 3 | Mode field |
| buf_full | input | 1 | Bridge write buffer is full |
| pready | output | 1 | Bus ready, low during a stall |
| pad_in | input | 4 | Pad levels of test-reset, data-in, mode-select, test-clock |
| core_in | output | 4 | Inputs seen by the debug core |
| gpio_own | output | 5 | Pad is owned by the GPIO controller |
| pu_en | output | 5 | Pull-up enable |
| pd_en | output | 5 | Pull-down enable |

## Verification
Two functions can meet in one cycle: a bus stall and the start of a pad's forcing sequence. A write that changes the released set while buf_full is high must hold pready low without letting any pad begin forcing early. The bench provokes this with directed and random writes under random buf_full. In the stall cycle it checks that core_in and gpio_own still match the old mode. It then checks that forcing begins only after the completing edge and that ownership moves one cycle later.

// File: rtl/swj_pkg.sv
// Package: shared constants, pad state type and the mode decode.
// Assumes five pads in fixed order: 0 test-reset, 1 data-in,
// 2 mode-select, 3 test-clock, 4 data-out.
package swj_pkg;
    localparam int N_PADS  = 5;
    localparam int N_INS   = 4;
    localparam int MODE_W  = 3;

    // Safe core-input levels during forcing: clock low, others high.
    localparam logic [N_INS-1:0]  SAFE_LVL = 4'b0111;
    localparam logic [N_PADS-1:0] PU_MASK  = 5'b00111;
    localparam logic [N_PADS-1:0] PD_MASK  = 5'b01000;

    typedef enum logic [1:0] {
        PAD_DBG   = 2'd0,
        PAD_FORCE = 2'd1,
        PAD_GPIO  = 2'd2
    } pad_st_e;

    // Map a mode code to the set of pads given to GPIO.
    function automatic logic [N_PADS-1:0] rel_of_mode(input logic [MODE_W-1:0] m);
        case (m)
            3'b000:  return 5'b00000;
            3'b001:  return 5'b00001;
            3'b010:  return 5'b10011;
            default: return 5'b11111;
        endcase
    endfunction
endpackage

// File: rtl/swj_bus_ctl.sv
// Bus side: holds the released-pad set, decodes writes and stalls
// pready for one cycle when a set change meets a full write buffer.
// Assumes the peripheral bus two-phase protocol (psel, then penable).
module swj_bus_ctl
    import swj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [MODE_W-1:0] pwdata,
    input  logic              buf_full,
    output logic              pready,
    output logic [N_PADS-1:0] rel_next
);
    logic [N_PADS-1:0] rel_q;
    logic              stall_q;
    logic              wr_acc;
    logic [N_PADS-1:0] rel_new;
    logic              chg;

    // Decode access, the candidate set and the stall condition.
    always_comb begin
        wr_acc   = psel && penable && pwrite;
        rel_new  = rel_of_mode(pwdata);
        chg      = (rel_new != rel_q);
        pready   = !(wr_acc && chg && buf_full && !stall_q);
        rel_next = (wr_acc && pready) ? rel_new : rel_q;
    end

    // Register the released set and remember a stall already served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            rel_q   <= rel_next;
            stall_q <= wr_acc && !pready;
        end
    end
endmodule

// File: rtl/swj_pad_seq.sv
// Per-pad sequencer: debug -> forcing -> GPIO on release, any state
// straight back to debug when reclaimed. Assumes target is the set
// that takes effect at the coming edge.
module swj_pad_seq
    import swj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PADS-1:0] target,
    output logic [N_PADS-1:0] gpio_own,
    output logic [N_PADS-1:0] forced
);
    for (genvar i = 0; i < N_PADS; i++) begin : g_pad
        pad_st_e st;

        // Step one pad's ownership state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st <= PAD_DBG;
            end else if (!target[i]) begin
                st <= PAD_DBG;
            end else begin
                case (st)
                    PAD_DBG:   st <= PAD_FORCE;
                    PAD_FORCE: st <= PAD_GPIO;
                    default:   st <= PAD_GPIO;
                endcase
            end
        end

        assign gpio_own[i] = (st == PAD_GPIO);
        assign forced[i]   = (st != PAD_DBG);
    end
endmodule

// File: rtl/swj_pad_mux.sv
// Output side: forces core inputs to safe levels and gates the pulls
// by ownership. Assumes pad bit order from swj_pkg.
module swj_pad_mux
    import swj_pkg::*;
(
    input  logic [N_INS-1:0]  pad_in,
    input  logic [N_PADS-1:0] forced,
    input  logic [N_PADS-1:0] gpio_own,
    output logic [N_INS-1:0]  core_in,
    output logic [N_PADS-1:0] pu_en,
    output logic [N_PADS-1:0] pd_en
);
    for (genvar i = 0; i < N_INS; i++) begin : g_in
        assign core_in[i] = forced[i] ? SAFE_LVL[i] : pad_in[i];
    end

    // Pulls stay on as long as the debug side owns the pad.
    always_comb begin
        pu_en = PU_MASK & ~gpio_own;
        pd_en = PD_MASK & ~gpio_own;
    end
endmodule

// File: rtl/swj_pin_release.sv
// Top: debug port pin release controller. Connects the bus control,
// the per-pad sequencer and the output mux.
module swj_pin_release
    import swj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [MODE_W-1:0] pwdata,
    input  logic              buf_full,
    output logic              pready,
    input  logic [N_INS-1:0]  pad_in,
    output logic [N_INS-1:0]  core_in,
    output logic [N_PADS-1:0] gpio_own,
    output logic [N_PADS-1:0] pu_en,
    output logic [N_PADS-1:0] pd_en
);
    logic [N_PADS-1:0] rel_next;
    logic [N_PADS-1:0] forced;

    swj_bus_ctl u_bus (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .buf_full(buf_full),
        .pready(pready), .rel_next(rel_next)
    );

    swj_pad_seq u_seq (
        .clk(clk), .rst_n(rst_n), .target(rel_next),
        .gpio_own(gpio_own), .forced(forced)
    );

    swj_pad_mux u_mux (
        .pad_in(pad_in), .forced(forced), .gpio_own(gpio_own),
        .core_in(core_in), .pu_en(pu_en), .pd_en(pd_en)
    );
endmodule

// File: rtl/swj_pin_release_chk.sv
// Checker for swj_pin_release, attached by bind below.
module swj_pin_release_chk
    import swj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              buf_full,
    input logic              pready,
    input logic [N_INS-1:0]  core_in,
    input logic [N_PADS-1:0] gpio_own,
    input logic [N_PADS-1:0] pu_en,
    input logic [N_PADS-1:0] pd_en
);
    for (genvar i = 0; i < N_INS; i++) begin : g_chk
        assert_release_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gpio_own[i]) |-> $past(core_in[i]) == SAFE_LVL[i]);
        assert_gpio_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gpio_own[i] |-> core_in[i] == SAFE_LVL[i]);
    end

    for (genvar i = 0; i < N_PADS; i++) begin : g_pull
        assert_pulls_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gpio_own[i] ? (!pu_en[i] && !pd_en[i])
                        : (pu_en[i] == PU_MASK[i] && pd_en[i] == PD_MASK[i]));
    end

    assert_one_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pready |=> pready);

    assert_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && !buf_full) |-> pready);

    assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |-> pready);
endmodule

bind swj_pin_release swj_pin_release_chk u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .buf_full(buf_full), .pready(pready),
    .core_in(core_in), .gpio_own(gpio_own), .pu_en(pu_en), .pd_en(pd_en)
);

// File: tb/swj_pin_release_bench.sv
module swj_pin_release_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0, buf_full = 1'b0;
    logic [2:0] pwdata = '0;
    logic [3:0] pad_in = '0;
    logic       pready;
    logic [3:0] core_in;
    logic [4:0] gpio_own, pu_en, pd_en;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_rel = '0;

    swj_pin_release u_swj_pin_release (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .buf_full(buf_full),
        .pready(pready), .pad_in(pad_in), .core_in(core_in),
        .gpio_own(gpio_own), .pu_en(pu_en), .pd_en(pd_en)
    );

    always #2 clk = ~clk;

    function automatic logic [4:0] mode_set(input logic [2:0] m);
        if (m == 3'b000) return 5'b00000;
        if (m == 3'b001) return 5'b00001;
        if (m == 3'b010) return 5'b10011;
        return 5'b11111;
    endfunction

    function automatic logic [3:0] core_exp(input logic [4:0] f, input logic [3:0] p);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = f[i] ? ((i == 3) ? 1'b0 : 1'b1) : p[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check ownership, pulls and core inputs against an expected owned/forced set.
    task automatic chk_pads(input string req, input logic [4:0] own, input logic [4:0] frc);
        chk({req, " own"}, 32'(gpio_own), 32'(own));
        chk({req, " pu"}, 32'(pu_en), 32'(5'b00111 & ~own));
        chk({req, " pd"}, 32'(pd_en), 32'(5'b01000 & ~own));
        chk({req, " core"}, 32'(core_in), 32'(core_exp(frc, pad_in)));
    endtask

    task automatic do_write(input logic [2:0] d, input logic bf);
        logic [4:0] m;
        logic       stall_exp;
        int         stalls;
        m = mode_set(d);
        stall_exp = (m != exp_rel) && bf;
        stalls = 0;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; pwdata = d; buf_full = bf;
        @(negedge clk);
        penable = 1'b1;
        #1;
        while (!pready && stalls < 3) begin
            stalls++;
            // R7: no forcing begins while the write is stalled.
            chk_pads("R7 stall", exp_rel, exp_rel);
            @(negedge clk);
            #1;
        end
        chk(stall_exp ? "R7 stall count" : "R8 no stall", 32'(stalls), stall_exp ? 1 : 0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        // R3/R4/R6: forcing cycle for new pads, reclaimed pads back at once.
        chk_pads("R3 R6 first", exp_rel & m, m);
        @(negedge clk);
        #1;
        chk_pads("R2 R4 R5 settled", m, m);
        exp_rel = m;
    endtask

    task automatic do_noop(input logic [2:0] d, input logic wr, input logic en);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; pwdata = d;
        @(negedge clk);
        penable = en;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        #1;
        chk_pads("R9 ignored", exp_rel, exp_rel);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        pad_in = 4'b1010;
        repeat (3) @(negedge clk);
        #1;
        chk_pads("R1 in reset", 5'b00000, 5'b00000);
        chk("R1 pready", 32'(pready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_pads("R1 after reset", 5'b00000, 5'b00000);

        // Directed walk through all codes, stalled and not.
        do_write(3'b001, 1'b1);
        do_write(3'b001, 1'b1);
        do_write(3'b010, 1'b0);
        do_write(3'b100, 1'b1);
        do_write(3'b000, 1'b1);
        do_write(3'b111, 1'b0);
        do_write(3'b010, 1'b1);
        do_write(3'b011, 1'b1);
        do_write(3'b101, 1'b0);
        do_write(3'b110, 1'b1);
        do_noop(3'b000, 1'b0, 1'b1);
        do_noop(3'b000, 1'b1, 1'b0);

        // Reset mid-operation returns all pads to the debug side.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk_pads("R1 reset again", 5'b00000, 5'b00000);
        rst_n = 1'b1;
        exp_rel = '0;

        for (int k = 0; k < 80; k++) begin
            pad_in = 4'($urandom);
            if (($urandom % 6) == 0)
                do_noop(3'($urandom), 1'($urandom), 1'b0);
            else
                do_write(3'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule